// File: doc/BRIEF.md
# Page Hamming ECC Snooping Controller

The block sits beside a NAND flash data path and watches every data word that crosses it. It builds a single-error-correct, double-error-detect Hamming code over a whole page in one pass. Each page access begins with a one-cycle page-start pulse. That pulse clears the accumulated parity and latches the page size and the transfer direction.

On a write, the two 16-bit parity registers hold the four code bytes once the page data has gone by. Software copies them into the spare area.

On a read, the four stored code bytes follow the page data directly. The block captures them and forms the syndrome. It then reports one of four outcomes: no error, a correctable data error with its word and bit position, a single flipped bit inside the code bytes, or an uncorrectable pattern. An erased page, with every data and code byte at 0xFF, reports the uncorrectable flag with an all-ones locator, so software can recognise it and not treat it as corrupt. The data width is a parameter, 8 or 16 bits.

Top module: `nfecc_snoop`

## Requirements
- R1: A page-start pulse clears the parity, the captured code, the word counter and all flags. It latches `page_mode` and `dir_read`, so later changes on those inputs have no effect until the next pulse. A strobe in the same cycle as the pulse is taken as word 0 of the new page.
- R2: The page data length is 512 << `page_mode` bytes: 512, 1024, 2048 or 4096 bytes of data, which are 528, 1056, 2112 or 4224 bytes with the spare area. One strobe carries one bus word.
- R3: Every data bit has an index equal to word*16 + bit, where the word is counted in bus words from 0 and the bit runs 0..BUS_W-1. Bit k (0..15) of the true parity at address 0 is the XOR of all data bits whose index has bit k set. Bit k of the complement parity at address 1 is the XOR of all data bits whose index has bit k clear. Code bytes 0 and 1 are address 0 bits [7:0] and [15:8]. Code bytes 2 and 3 are address 1 bits [7:0] and [15:8].
- R4: Strobes after the page data leave the parity registers unchanged. Strobes after the four code bytes are ignored.
- R5: On a read, the four bytes after the data are captured in order as the stored code. An 8-bit bus takes one byte per strobe. A 16-bit bus takes one halfword per strobe, with the lower-numbered byte in bits [7:0]. The status and locator reflect the check from the clock edge that samples the last code byte and stay unchanged until the next page start.
- R6: When the stored code matches, the status (address 2) reads 0 and the locator (address 3) holds the computed true parity.
- R7: A single flipped data bit gives status 3'b001 (bit 0 = error seen). The locator's bits [3:0] hold the bit offset and bits [15:4] hold the word offset.
- R8: A single flipped bit inside the stored code gives status 3'b011 (bit 1 = error lies in the code bytes). The locator holds the XOR of the computed and stored true parity.
- R9: Any other nonzero syndrome gives status 3'b101 (bit 2 = uncorrectable), and the locator holds the same XOR. An erased page (all 0xFF, code included) gives 3'b101 with locator 16'hFFFF.
- R10: In write direction the status stays 0, and the locator holds the computed true parity.
- R11: `reg_rdata` shows the register selected by `reg_addr` in the same cycle: 0 true parity, 1 complement parity, 2 status in bits [2:0], 3 locator. After reset, all four read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_start | input | 1 | One-cycle pulse that opens a new page access |
| dir_read | input | 1 | Direction latched at page start: 1 read/check, 0 write |
| page_mode | input | 2 | Page size code latched at page start |
| strobe | input | 1 | A data word is on `data` this cycle |
| data | input | BUS_W | Snooped data word |
| reg_addr | input | 2 | Register select |
| reg_rdata | output | 16 | Selected register contents |

## Verification
Opening a page and taking a data word can land in the same cycle. The bench provokes this by raising the page-start pulse and the strobe together with the first byte of a new page. While the rest of that page streams in, it also moves the page-size input to another value. The result is judged by a clean check: status 0 and parity equal to the bench's own model of the full page. If the first word were dropped, or the latched size were disturbed, the check would come out as an error.

// File: rtl/nfecc_pkg.sv
`timescale 1ns/1ps
package nfecc_pkg;
    // widest page: 4096 data words plus 4 code words
    localparam int CNT_W   = 13;
    localparam int IDX_W   = 16;
    localparam int BIT_W   = 4;
    localparam int WORD_W  = IDX_W - BIT_W;
    localparam int CODE_W  = 2 * IDX_W;

    // status bit positions
    localparam int ST_ANY   = 0;
    localparam int ST_CODE  = 1;
    localparam int ST_MULTI = 2;

    typedef enum logic [1:0] {
        RA_PAR_T = 2'd0,
        RA_PAR_C = 2'd1,
        RA_STAT  = 2'd2,
        RA_LOC   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  par_t;
        logic [IDX_W-1:0]  par_c;
        logic [CODE_W-1:0] stored;
        logic              done;
        logic              rd;
        logic [1:0]        mode;
    } snoop_state_t;
endpackage

// File: rtl/nfecc_par_step.sv
`timescale 1ns/1ps
// Parity contribution of one bus word at a given word index.
module nfecc_par_step
    import nfecc_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic [BUS_W-1:0]  word_data,
    input  logic [WORD_W-1:0] word_idx,
    output logic [IDX_W-1:0]  delta_t,
    output logic [IDX_W-1:0]  delta_c
);
    logic word_par;

    assign word_par = ^word_data;

    // bit-index part of the index: split each word by bit position
    always_comb begin
        delta_t[BIT_W-1:0] = '0;
        delta_c[BIT_W-1:0] = '0;
        for (int j = 0; j < BUS_W; j++) begin
            for (int k = 0; k < BIT_W; k++) begin
                if (j[k]) delta_t[k] = delta_t[k] ^ word_data[j];
                else      delta_c[k] = delta_c[k] ^ word_data[j];
            end
        end
    end

    // word-index part: whole-word parity steered by each address bit
    for (genvar k = 0; k < WORD_W; k++) begin : g_widx
        assign delta_t[BIT_W+k] = word_idx[k]  & word_par;
        assign delta_c[BIT_W+k] = !word_idx[k] & word_par;
    end
endmodule

// File: rtl/nfecc_judge.sv
`timescale 1ns/1ps
// Syndrome classification and locator selection.
module nfecc_judge
    import nfecc_pkg::*;
(
    input  logic [IDX_W-1:0]  calc_t,
    input  logic [IDX_W-1:0]  calc_c,
    input  logic [CODE_W-1:0] stored,
    input  logic              valid,
    output logic [2:0]        flags,
    output logic [IDX_W-1:0]  loc
);
    logic [IDX_W-1:0]  syn_t, syn_c;
    logic [CODE_W-1:0] syn;
    logic              any_err, data_one, code_one;

    assign syn_t    = calc_t ^ stored[IDX_W-1:0];
    assign syn_c    = calc_c ^ stored[CODE_W-1:IDX_W];
    assign syn      = {syn_c, syn_t};
    assign any_err  = |syn;
    assign data_one = &(syn_t ^ syn_c);
    assign code_one = ($countones(syn) == 1);

    always_comb begin
        flags           = '0;
        flags[ST_ANY]   = valid & any_err;
        flags[ST_CODE]  = valid & code_one;
        flags[ST_MULTI] = valid & any_err & !data_one & !code_one;
        loc             = (valid && any_err) ? syn_t : calc_t;
    end
endmodule

// File: rtl/nfecc_snoop.sv
`timescale 1ns/1ps
module nfecc_snoop
    import nfecc_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             page_start,
    input  logic             dir_read,
    input  logic [1:0]       page_mode,
    input  logic             strobe,
    input  logic [BUS_W-1:0] data,
    input  logic [1:0]       reg_addr,
    output logic [15:0]      reg_rdata
);
    localparam int BYTES_W    = BUS_W / 8;
    localparam int BASE_WORDS = 512 / BYTES_W;
    localparam int CODE_WORDS = 4 / BYTES_W;

    snoop_state_t s_q, s_d, base;

    logic [CNT_W-1:0] n_words, n_total;
    logic             in_data, in_code, last_code;
    logic [1:0]       code_slot;
    logic [IDX_W-1:0] step_t, step_c, loc;
    logic [2:0]       flags;

    // page-start view of the state, before this cycle's strobe
    always_comb begin
        base = s_q;
        if (page_start) begin
            base.cnt    = '0;
            base.par_t  = '0;
            base.par_c  = '0;
            base.stored = '0;
            base.done   = 1'b0;
            base.rd     = dir_read;
            base.mode   = page_mode;
        end
    end

    assign n_words   = CNT_W'(BASE_WORDS) << base.mode;
    assign n_total   = n_words + CNT_W'(CODE_WORDS);
    assign in_data   = base.cnt < n_words;
    assign in_code   = !in_data && (base.cnt < n_total);
    assign last_code = base.cnt == (n_total - CNT_W'(1));
    assign code_slot = 2'(base.cnt - n_words);

    nfecc_par_step #(.BUS_W(BUS_W)) u_step (
        .word_data (data),
        .word_idx  (base.cnt[WORD_W-1:0]),
        .delta_t   (step_t),
        .delta_c   (step_c)
    );

    always_comb begin
        s_d = base;
        if (strobe) begin
            if (in_data) begin
                s_d.par_t = base.par_t ^ step_t;
                s_d.par_c = base.par_c ^ step_c;
                s_d.cnt   = base.cnt + CNT_W'(1);
            end else if (in_code) begin
                s_d.stored[int'(code_slot)*BUS_W +: BUS_W] = data;
                s_d.cnt = base.cnt + CNT_W'(1);
                if (last_code && base.rd) s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    nfecc_judge u_judge (
        .calc_t (s_q.par_t),
        .calc_c (s_q.par_c),
        .stored (s_q.stored),
        .valid  (s_q.done),
        .flags  (flags),
        .loc    (loc)
    );

    always_comb begin
        unique case (reg_addr_e'(reg_addr))
            RA_PAR_T: reg_rdata = s_q.par_t;
            RA_PAR_C: reg_rdata = s_q.par_c;
            RA_STAT:  reg_rdata = {13'd0, flags};
            default:  reg_rdata = loc;
        endcase
    end

    // R1
    clr_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_start |=> (flags == 3'b000));

    // R4
    par_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !page_start && !in_data) |=> ($stable(s_q.par_t) && $stable(s_q.par_c)));

    // R5
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && !page_start) |=> ($stable(flags) && $stable(loc)));

    // R10
    wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.rd |-> (flags == 3'b000));
endmodule

// File: tb/sim_nfecc_snoop.sv
`timescale 1ns/1ps
module sim_nfecc_snoop;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_start = 1'b0;
    logic        dir_read = 1'b0;
    logic [1:0]  page_mode = 2'd0;
    logic        strobe = 1'b0;
    logic [7:0]  data = 8'd0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] pg [0:4095];

    always #2.5 clk = ~clk;

    nfecc_snoop #(.BUS_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .page_start(page_start), .dir_read(dir_read),
        .page_mode(page_mode), .strobe(strobe), .data(data),
        .reg_addr(reg_addr), .reg_rdata(reg_rdata)
    );

    // kind: 0 clean, 1 one data bit, 2 one code bit, 3 two data bits
    typedef struct packed {
        logic [1:0]  mode;
        logic        rd;
        logic [1:0]  kind;
        logic [11:0] w1;
        logic [3:0]  b1;
        logic [11:0] w2;
        logic [3:0]  b2;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 2'd0, 12'd0,    4'd0, 12'd0,   4'd0, 8'd3},
        '{2'd0, 1'b1, 2'd1, 12'd5,    4'd2, 12'd0,   4'd0, 8'd17},
        '{2'd1, 1'b1, 2'd1, 12'd1023, 4'd7, 12'd0,   4'd0, 8'd40},
        '{2'd0, 1'b1, 2'd1, 12'd0,    4'd0, 12'd0,   4'd0, 8'd99},
        '{2'd0, 1'b1, 2'd2, 12'd0,    4'd3, 12'd0,   4'd0, 8'd5},
        '{2'd0, 1'b1, 2'd2, 12'd1,    4'd9, 12'd0,   4'd0, 8'd61},
        '{2'd2, 1'b1, 2'd3, 12'd10,   4'd1, 12'd700, 4'd6, 8'd128},
        '{2'd0, 1'b0, 2'd0, 12'd0,    4'd0, 12'd0,   4'd0, 8'd9},
        '{2'd3, 1'b1, 2'd1, 12'd4095, 4'd7, 12'd0,   4'd0, 8'd222}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] v);
        reg_addr = a;
        #0.1;
        v = reg_rdata;
    endtask

    task automatic start_page(input logic [1:0] m, input logic r);
        @(negedge clk);
        page_start = 1'b1; page_mode = m; dir_read = r; strobe = 1'b0;
        @(negedge clk);
        page_start = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        strobe = 1'b1; data = d;
    endtask

    task automatic idle();
        @(negedge clk);
        strobe = 1'b0;
    endtask

    function automatic void fill(input int n, input logic [7:0] seed);
        for (int w = 0; w < n; w++) pg[w] = 8'((w * 7) ^ (w >> 4)) + seed;
    endfunction

    // reference code per R3: {complement, true}
    function automatic logic [31:0] model(input int n);
        logic [15:0] pt, pc, idx;
        pt = '0; pc = '0;
        for (int w = 0; w < n; w++)
            for (int b = 0; b < 8; b++)
                if (pg[w][b]) begin
                    idx = {w[11:0], b[3:0]};
                    for (int k = 0; k < 16; k++)
                        if (idx[k]) pt[k] = ~pt[k]; else pc[k] = ~pc[k];
                end
        return {pc, pt};
    endfunction

    task automatic push_code(input logic [31:0] c);
        for (int i = 0; i < 4; i++) push(c[i*8 +: 8]);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v, v2;
        logic [31:0] clean, rx, code;
        logic [15:0] e_loc;
        logic [2:0]  e_st;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state of all four registers
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), v);
            chk("R11 reset", 32'(v), 32'd0);
        end

        for (int t = 0; t < NV; t++) begin
            n = 512 << VECS[t].mode;
            fill(n, VECS[t].seed);
            clean = model(n);
            if (VECS[t].kind == 2'd1 || VECS[t].kind == 2'd3)
                pg[VECS[t].w1][VECS[t].b1] = ~pg[VECS[t].w1][VECS[t].b1];
            if (VECS[t].kind == 2'd3)
                pg[VECS[t].w2][VECS[t].b2] = ~pg[VECS[t].w2][VECS[t].b2];
            rx = model(n);
            code = clean;
            if (VECS[t].kind == 2'd2)
                code[{VECS[t].w1[0], VECS[t].b1}] = ~code[{VECS[t].w1[0], VECS[t].b1}];

            start_page(VECS[t].mode, VECS[t].rd);
            for (int w = 0; w < n; w++) push(pg[w]);
            push_code(code);
            idle();

            // R2 R3 parity over exactly the page data
            rd_reg(2'd0, v);  chk("R3 true parity", 32'(v), 32'(rx[15:0]));
            rd_reg(2'd1, v);  chk("R3 complement parity", 32'(v), 32'(rx[31:16]));

            if (!VECS[t].rd) begin
                e_st = 3'b000; e_loc = rx[15:0];           // R10
            end else begin
                case (VECS[t].kind)
                    2'd0: begin e_st = 3'b000; e_loc = rx[15:0]; end                 // R6
                    2'd1: begin e_st = 3'b001; e_loc = {VECS[t].w1, VECS[t].b1}; end // R7
                    2'd2: begin e_st = 3'b011; e_loc = rx[15:0] ^ code[15:0]; end    // R8
                    default: begin
                        e_st = 3'b101;                                               // R9
                        e_loc = {VECS[t].w1, VECS[t].b1} ^ {VECS[t].w2, VECS[t].b2};
                    end
                endcase
            end
            rd_reg(2'd2, v);  chk("R5 R6 R7 R8 R9 R10 status", 32'(v), 32'(e_st));
            rd_reg(2'd3, v);  chk("R5 R6 R7 R8 R9 R10 locator", 32'(v), 32'(e_loc));

            if (t == 1) begin
                // R4 R5: extra strobes after the code leave everything unchanged
                push(8'h5A); push(8'hA5); push(8'h00);
                idle();
                rd_reg(2'd2, v);  chk("R5 status held", 32'(v), 32'(e_st));
                rd_reg(2'd3, v);  chk("R5 locator held", 32'(v), 32'(e_loc));
                rd_reg(2'd0, v);  chk("R4 parity held", 32'(v), 32'(rx[15:0]));
            end
            if (t == 7) begin
                // R4 R10: write direction, code strobes do not disturb parity
                rd_reg(2'd1, v);  chk("R4 write parity held", 32'(v), 32'(clean[31:16]));
            end
        end

        // R9 erased page
        fill(512, 8'd0);
        for (int w = 0; w < 512; w++) pg[w] = 8'hFF;
        start_page(2'd0, 1'b1);
        for (int w = 0; w < 512; w++) push(8'hFF);
        push_code(32'hFFFF_FFFF);
        idle();
        rd_reg(2'd2, v);  chk("R9 erased status", 32'(v), 32'h5);
        rd_reg(2'd3, v);  chk("R9 erased locator", 32'(v), 32'hFFFF);

        // R1 page start with a strobe in the same cycle, size input moved mid-page
        fill(512, 8'd77);
        clean = model(512);
        @(negedge clk);
        page_start = 1'b1; page_mode = 2'd0; dir_read = 1'b1;
        strobe = 1'b1; data = pg[0];
        @(negedge clk);
        page_start = 1'b0; page_mode = 2'd3; dir_read = 1'b0;
        data = pg[1];
        for (int w = 2; w < 512; w++) push(pg[w]);
        push_code(clean);
        idle();
        rd_reg(2'd0, v);  chk("R1 collision parity", 32'(v), 32'(clean[15:0]));
        rd_reg(2'd2, v);  chk("R1 collision status", 32'(v), 32'd0);

        // R1 new page start clears flags of a failed check
        fill(512, 8'd1);
        clean = model(512);
        start_page(2'd0, 1'b1);
        for (int w = 0; w < 512; w++) push(pg[w]);
        push_code(~clean);
        idle();
        rd_reg(2'd2, v2); chk("R9 inverted code status", 32'(v2), 32'h5);
        start_page(2'd0, 1'b1);
        rd_reg(2'd2, v);  chk("R1 flags cleared", 32'(v), 32'd0);
        rd_reg(2'd0, v);  chk("R1 parity cleared", 32'(v), 32'd0);

        summary();
        $finish;
    end
endmodule